// File: doc/BRIEF.md
# LIN Break and Wake-Up Detector

This block measures how long the sampled receive line of a LIN node stays dominant (low), counting in bit times from a one-cycle tick supplied by an external baud generator. The count restarts whenever the line goes recessive (high). It stops at its largest value rather than wrapping.

A two-bit node-state input sets the break length. In sleep the length is short, and a break there also counts as a wake-up. A slave waiting for a break needs the longest length. A slave in an active frame needs one bit time less than that.

When the dominant count first reaches the length for the current state, the block emits a one-cycle break pulse. In sleep it emits a wake pulse with it. A sticky break flag is set at the same time and stays set until a clear strobe from the register read path arrives. When the LIN enable is low, or the node state is the unused code, no pulse is produced.

Top module: `lin_brk_detect`

## Requirements
- R1: While `lin_en` is 1 and `rxd` is 0, `dominant_bits` rises by one on each clock edge that samples `bit_tick` high. It does not change on other edges. It reads 0 after any edge that samples `rxd` high.
- R2: `dominant_bits` stops at 2^CNT_W-1 (15 by default) and does not wrap while the line stays low.
- R3: With `node_mode` = 2'b00 (sleep), `brk_pulse` and `wake_pulse` go high together for one cycle. This happens in the cycle after the edge at which the dominant count reaches 4.
- R4: With `node_mode` = 2'b01 (slave waiting for break), `brk_pulse` goes high for one cycle once the dominant count reaches 11. `wake_pulse` stays low.
- R5: With `node_mode` = 2'b10 (slave active), `brk_pulse` goes high for one cycle once the dominant count reaches 10. `wake_pulse` stays low.
- R6: Each low period gives at most one break pulse. If `node_mode` changes during a low period, the new length applies from that edge on. The pulse fires at once if the count already meets the new length and no pulse has yet been given in that period.
- R7: `brk_flag` is set on the edge that raises `brk_pulse` and holds until an edge samples `flag_clr` high. When a set and a clear fall on the same edge, the set wins.
- R8: While `lin_en` is 0, `dominant_bits` holds 0 and no pulse is produced. With `node_mode` = 2'b11 the count still runs, but no pulse is produced.
- R9: While `rst_n` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lin_en | input | 1 | LIN mode enable |
| node_mode | input | 2 | Node state: 00 sleep, 01 waiting for break, 10 active, 11 unused |
| rxd | input | 1 | Sampled receive line, 0 = dominant |
| bit_tick | input | 1 | One-cycle strobe per bit time |
| flag_clr | input | 1 | Clears the sticky break flag (status or data read) |
| brk_pulse | output | 1 | One-cycle break detect |
| wake_pulse | output | 1 | One-cycle wake-up detect (sleep state only) |
| brk_flag | output | 1 | Sticky break flag |
| dominant_bits | output | CNT_W | Bit times counted in the current low period |

## Verification
The assertions assume that `rxd`, `bit_tick`, `node_mode` and `flag_clr` are synchronous to `clk` and stable around each rising edge. They also assume that `bit_tick` is a single-cycle strobe. The per-state threshold checks further assume that the parameter thresholds fit within the counter width.

The stimulus changes every input on the falling clock edge. It raises `bit_tick` for exactly one cycle, followed by at least one idle cycle. It changes the node state only between ticks, so each sampled state belongs to a well-defined count.

// File: rtl/lin_brk_pkg.sv
package lin_brk_pkg;

   typedef enum logic [1:0] {
      NODE_SLEEP    = 2'b00,
      NODE_WAIT_BRK = 2'b01,
      NODE_ACTIVE   = 2'b10,
      NODE_OFF      = 2'b11
   } node_mode_e;

endpackage

// File: rtl/lin_low_timer.sv
// Counts bit ticks while the line is dominant; clears on recessive, saturates.
module lin_low_timer #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic             line_low,
   input  logic             tick,
   output logic [CNT_W-1:0] cnt,
   output logic [CNT_W-1:0] cnt_nxt
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   always_comb begin
      if (!enable || !line_low)
         cnt_nxt = '0;
      else if (tick && (cnt != CNT_MAX))
         cnt_nxt = cnt + CNT_W'(1);
      else
         cnt_nxt = cnt;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt <= '0;
      else        cnt <= cnt_nxt;
   end
endmodule

// File: rtl/lin_brk_judge.sv
// Compares the next count with the state-dependent length; one shot per low period.
module lin_brk_judge
   import lin_brk_pkg::*;
#(
   parameter int CNT_W      = 4,
   parameter int SLEEP_LEN  = 4,
   parameter int WAIT_LEN   = 11,
   parameter int ACTIVE_LEN = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic             line_low,
   input  node_mode_e       mode,
   input  logic [CNT_W-1:0] cnt_nxt,
   output logic             brk_hit,
   output logic             brk_pulse,
   output logic             wake_pulse
);
   localparam logic [CNT_W-1:0] SLEEP_T  = CNT_W'(SLEEP_LEN);
   localparam logic [CNT_W-1:0] WAIT_T   = CNT_W'(WAIT_LEN);
   localparam logic [CNT_W-1:0] ACTIVE_T = CNT_W'(ACTIVE_LEN);

   logic [CNT_W-1:0] thr;
   logic             mode_ok;
   logic             fired;

   always_comb begin
      thr     = WAIT_T;
      mode_ok = 1'b1;
      case (mode)
         NODE_SLEEP:    thr = SLEEP_T;
         NODE_WAIT_BRK: thr = WAIT_T;
         NODE_ACTIVE:   thr = ACTIVE_T;
         default:       mode_ok = 1'b0;
      endcase
   end

   assign brk_hit = enable && line_low && mode_ok && !fired && (cnt_nxt >= thr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fired      <= 1'b0;
         brk_pulse  <= 1'b0;
         wake_pulse <= 1'b0;
      end else begin
         if (!enable || !line_low) fired <= 1'b0;
         else if (brk_hit)         fired <= 1'b1;
         brk_pulse  <= brk_hit;
         wake_pulse <= brk_hit && (mode == NODE_SLEEP);
      end
   end
endmodule

// File: rtl/lin_brk_flag.sv
// Sticky break flag; the parameter picks which of set/clear wins a tie.
module lin_brk_flag #(
   parameter bit SET_WINS = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic flag
);
   generate
      if (SET_WINS) begin : g_set_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   flag <= 1'b0;
            else if (set) flag <= 1'b1;
            else if (clr) flag <= 1'b0;
         end
      end else begin : g_clr_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   flag <= 1'b0;
            else if (clr) flag <= 1'b0;
            else if (set) flag <= 1'b1;
         end
      end
   endgenerate
endmodule

// File: rtl/lin_brk_detect.sv
module lin_brk_detect
   import lin_brk_pkg::*;
#(
   parameter int CNT_W      = 4,
   parameter int SLEEP_LEN  = 4,
   parameter int WAIT_LEN   = 11,
   parameter int ACTIVE_LEN = 10,
   parameter bit SET_WINS   = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lin_en,
   input  logic [1:0]       node_mode,
   input  logic             rxd,
   input  logic             bit_tick,
   input  logic             flag_clr,
   output logic             brk_pulse,
   output logic             wake_pulse,
   output logic             brk_flag,
   output logic [CNT_W-1:0] dominant_bits
);
   localparam int CNT_MAX = (1 << CNT_W) - 1;

   generate
      if (CNT_W < 2 || CNT_W > 16) begin : g_bad_width
         $error("lin_brk_detect: CNT_W out of range");
      end
      if (SLEEP_LEN < 1 || SLEEP_LEN > CNT_MAX) begin : g_bad_sleep
         $error("lin_brk_detect: SLEEP_LEN does not fit the counter");
      end
      if (WAIT_LEN < 1 || WAIT_LEN > CNT_MAX) begin : g_bad_wait
         $error("lin_brk_detect: WAIT_LEN does not fit the counter");
      end
      if (ACTIVE_LEN < 1 || ACTIVE_LEN > CNT_MAX) begin : g_bad_active
         $error("lin_brk_detect: ACTIVE_LEN does not fit the counter");
      end
   endgenerate

   logic             line_low;
   logic [CNT_W-1:0] cnt_nxt;
   logic             brk_hit;
   node_mode_e       mode;

   assign line_low = !rxd;
   assign mode     = node_mode_e'(node_mode);

   lin_low_timer #(.CNT_W(CNT_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .enable   (lin_en),
      .line_low (line_low),
      .tick     (bit_tick),
      .cnt      (dominant_bits),
      .cnt_nxt  (cnt_nxt)
   );

   lin_brk_judge #(
      .CNT_W      (CNT_W),
      .SLEEP_LEN  (SLEEP_LEN),
      .WAIT_LEN   (WAIT_LEN),
      .ACTIVE_LEN (ACTIVE_LEN)
   ) u_judge (
      .clk        (clk),
      .rst_n      (rst_n),
      .enable     (lin_en),
      .line_low   (line_low),
      .mode       (mode),
      .cnt_nxt    (cnt_nxt),
      .brk_hit    (brk_hit),
      .brk_pulse  (brk_pulse),
      .wake_pulse (wake_pulse)
   );

   lin_brk_flag #(.SET_WINS(SET_WINS)) u_flag (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (brk_hit),
      .clr   (flag_clr),
      .flag  (brk_flag)
   );
endmodule

// File: rtl/lin_brk_detect_chk.sv
module lin_brk_detect_chk #(
   parameter int CNT_W      = 4,
   parameter int SLEEP_LEN  = 4,
   parameter int WAIT_LEN   = 11,
   parameter int ACTIVE_LEN = 10
) (
   input logic             clk,
   input logic             rst_n,
   input logic             lin_en,
   input logic [1:0]       node_mode,
   input logic             rxd,
   input logic             bit_tick,
   input logic             flag_clr,
   input logic             brk_pulse,
   input logic             wake_pulse,
   input logic             brk_flag,
   input logic [CNT_W-1:0] dominant_bits
);
   localparam logic [CNT_W-1:0] C_MAX = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] C_SLP = CNT_W'(SLEEP_LEN);
   localparam logic [CNT_W-1:0] C_WT  = CNT_W'(WAIT_LEN);
   localparam logic [CNT_W-1:0] C_ACT = CNT_W'(ACTIVE_LEN);

   // R1
   count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lin_en && !rxd && bit_tick && dominant_bits != C_MAX)
      |=> dominant_bits == $past(dominant_bits) + CNT_W'(1));

   // R1
   count_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rxd |=> dominant_bits == '0);

   // R2
   count_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lin_en && !rxd && dominant_bits == C_MAX) |=> dominant_bits == C_MAX);

   // R3
   wake_with_brk_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wake_pulse |-> (brk_pulse && $past(node_mode) == 2'b00));

   // R3
   sleep_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (brk_pulse && $past(node_mode) == 2'b00) |-> dominant_bits >= C_SLP);

   // R4
   wait_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (brk_pulse && $past(node_mode) == 2'b01) |-> dominant_bits >= C_WT);

   // R5
   active_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (brk_pulse && $past(node_mode) == 2'b10) |-> dominant_bits >= C_ACT);

   // R6
   single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      brk_pulse |=> !brk_pulse);

   // R7
   flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (brk_pulse && !$past(flag_clr)) |-> brk_flag);

   // R7
   flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flag_clr |=> (!brk_flag || brk_pulse));

   // R8
   disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !lin_en |=> (!brk_pulse && dominant_bits == '0));

   // R8
   off_mode_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      node_mode == 2'b11 |=> !brk_pulse);
endmodule

bind lin_brk_detect lin_brk_detect_chk #(
   .CNT_W      (CNT_W),
   .SLEEP_LEN  (SLEEP_LEN),
   .WAIT_LEN   (WAIT_LEN),
   .ACTIVE_LEN (ACTIVE_LEN)
) u_chk (.*);

// File: tb/lin_brk_detect_test.sv
`timescale 1ns/1ps
module lin_brk_detect_test;
   localparam int CW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          lin_en = 1'b0;
   logic [1:0]    node_mode = 2'b01;
   logic          rxd = 1'b1;
   logic          bit_tick = 1'b0;
   logic          flag_clr = 1'b0;
   logic          brk_pulse, wake_pulse, brk_flag;
   logic [CW-1:0] dominant_bits;

   always #2 clk = ~clk;

   lin_brk_detect #(.CNT_W(CW)) uut (
      .clk(clk), .rst_n(rst_n), .lin_en(lin_en), .node_mode(node_mode),
      .rxd(rxd), .bit_tick(bit_tick), .flag_clr(flag_clr),
      .brk_pulse(brk_pulse), .wake_pulse(wake_pulse), .brk_flag(brk_flag),
      .dominant_bits(dominant_bits)
   );

   typedef struct {
      bit wake;
      int at_tick;
      int req;
   } exp_t;

   exp_t q[$];
   exp_t cur;
   int   checks = 0;
   int   fails = 0;
   int   ticks = 0;

   task automatic chk(bit ok, string req, string what, int act, int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic cyc(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic tick_n(int n);
      for (int i = 0; i < n; i++) begin
         bit_tick = 1'b1;
         cyc(1);
         bit_tick = 1'b0;
         cyc(1);
      end
   endtask

   task automatic expect_brk(bit wake, int at_tick, int req);
      exp_t e;
      e.wake = wake;
      e.at_tick = at_tick;
      e.req = req;
      q.push_back(e);
   endtask

   task automatic release_line();
      rxd = 1'b1;
      cyc(2);
   endtask

   // bench-side bit-time count of the current low period
   always @(posedge clk) begin
      if (!rst_n || rxd || !lin_en) ticks <= 0;
      else if (bit_tick)            ticks <= ticks + 1;
   end

   // monitor: pop and compare each break pulse
   always @(negedge clk) begin
      if (rst_n) begin
         if (wake_pulse && !brk_pulse)
            chk(1'b0, "R3", "wake pulse without break pulse", 1, 0);
         if (brk_pulse) begin
            if (q.size() == 0) begin
               chk(1'b0, "R6", "unexpected break pulse", 1, 0);
            end else begin
               cur = q.pop_front();
               chk(wake_pulse == cur.wake, $sformatf("R%0d", cur.req),
                   "wake pulse level", int'(wake_pulse), int'(cur.wake));
               chk(ticks == cur.at_tick, $sformatf("R%0d", cur.req),
                   "bit times at break pulse", ticks, cur.at_tick);
            end
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      chk(1'b0, "watchdog", "run did not finish", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      cyc(3);
      // R9 reset state
      chk(brk_pulse == 1'b0, "R9", "brk_pulse in reset", int'(brk_pulse), 0);
      chk(wake_pulse == 1'b0, "R9", "wake_pulse in reset", int'(wake_pulse), 0);
      chk(brk_flag == 1'b0, "R9", "brk_flag in reset", int'(brk_flag), 0);
      chk(dominant_bits == 0, "R9", "dominant_bits in reset", int'(dominant_bits), 0);
      rst_n = 1'b1;
      lin_en = 1'b1;
      cyc(2);

      // R1 counting and clearing
      node_mode = 2'b01;
      rxd = 1'b0;
      cyc(5);
      chk(dominant_bits == 0, "R1", "count without ticks", int'(dominant_bits), 0);
      tick_n(3);
      chk(dominant_bits == 3, "R1", "count after 3 ticks", int'(dominant_bits), 3);
      rxd = 1'b1;
      cyc(1);
      chk(dominant_bits == 0, "R1", "count after line high", int'(dominant_bits), 0);
      cyc(1);

      // R3 sleep: break + wake at 4
      node_mode = 2'b00;
      expect_brk(1'b1, 4, 3);
      rxd = 1'b0;
      tick_n(4);
      chk(brk_flag == 1'b1, "R7", "flag after sleep break", int'(brk_flag), 1);
      tick_n(3);
      release_line();
      cyc(4);
      chk(brk_flag == 1'b1, "R7", "flag holds", int'(brk_flag), 1);
      flag_clr = 1'b1;
      cyc(1);
      flag_clr = 1'b0;
      chk(brk_flag == 1'b0, "R7", "flag after clear", int'(brk_flag), 0);

      // R4 waiting for break: 11 needed, 10 not enough
      node_mode = 2'b01;
      rxd = 1'b0;
      tick_n(10);
      release_line();
      expect_brk(1'b0, 11, 4);
      rxd = 1'b0;
      tick_n(12);
      release_line();

      // R5 active: 10 needed, 9 not enough
      node_mode = 2'b10;
      rxd = 1'b0;
      tick_n(9);
      release_line();
      expect_brk(1'b0, 10, 5);
      rxd = 1'b0;
      tick_n(10);
      release_line();

      // R2 saturation with single pulse over a long low period
      node_mode = 2'b01;
      expect_brk(1'b0, 11, 4);
      rxd = 1'b0;
      tick_n(20);
      chk(dominant_bits == 15, "R2", "saturated count", int'(dominant_bits), 15);
      release_line();

      // R6 mode change mid-period: waiting at 6 -> sleep fires at once
      node_mode = 2'b01;
      rxd = 1'b0;
      tick_n(6);
      expect_brk(1'b1, 6, 6);
      node_mode = 2'b00;
      cyc(2);
      tick_n(5);
      release_line();

      // R8 LIN disabled: no count, no pulse
      lin_en = 1'b0;
      node_mode = 2'b00;
      rxd = 1'b0;
      tick_n(12);
      chk(dominant_bits == 0, "R8", "count with LIN off", int'(dominant_bits), 0);
      release_line();
      lin_en = 1'b1;
      // R8 unused state: count runs, no pulse
      node_mode = 2'b11;
      rxd = 1'b0;
      tick_n(12);
      chk(dominant_bits == 12, "R8", "count in unused state", int'(dominant_bits), 12);
      release_line();

      // R7 set wins over same-edge clear
      flag_clr = 1'b1;
      cyc(1);
      flag_clr = 1'b0;
      chk(brk_flag == 1'b0, "R7", "flag cleared before tie", int'(brk_flag), 0);
      node_mode = 2'b00;
      expect_brk(1'b1, 4, 7);
      rxd = 1'b0;
      tick_n(3);
      bit_tick = 1'b1;
      flag_clr = 1'b1;
      cyc(1);
      bit_tick = 1'b0;
      flag_clr = 1'b0;
      chk(brk_flag == 1'b1, "R7", "set wins over clear", int'(brk_flag), 1);
      cyc(1);
      release_line();

      cyc(3);
      chk(q.size() == 0, "R6", "expected pulses not seen", q.size(), 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule